// File: doc/BRIEF.md
# Button Press Capture and Encoder

This block turns a bank of fifteen push buttons into a stream of discrete press events. The buttons arrive as two groups, a lower group of eight and an upper group of seven. The block merges them into one 15-bit mask, with the upper group placed above bit 7. Each event carries the captured mask, the index of the pressed button and a one-cycle valid strobe. A held button produces exactly one event: before a new press is accepted, every button must have been let go.

The index is not computed by a priority encoder. After capture, a small shift engine moves the captured value right by one place per clock. It stops when the remaining value is exactly 1, and the number of shifts taken is the index. When several buttons are down at once, only the highest set bit ever leaves a remaining value of 1, so the reported index is that bit's position. The engine is given a fixed budget of shift iterations. If the budget runs out before the value reaches 1, the event is still reported, with index 0 and an error flag. This happens when the button was already released at the capture cycle, or when the highest set bit lies beyond the budget.

The controller has five states:
- **WAIT_RELEASE**: the reset state. It moves to WAIT_PRESS when the mask is all zero.
- **WAIT_PRESS**: it moves to CAPTURE when the mask is non-zero.
- **CAPTURE**: it samples the mask again and always moves to SHIFT.
- **SHIFT**: it goes to DONE when the value equals 1 (success) or when the budget is exhausted (error). Otherwise it shifts once and stays in SHIFT.
- **DONE**: it drives valid and always moves back to WAIT_RELEASE.

Debouncing and display of the results are left to other blocks.

Top module: `btn_press_capture`

## Requirements
- R1: The merged mask bit i equals `btn_lo[i]` for i below `LO_W`, and mask bit `LO_W+j` equals `btn_hi[j]`. `press_mask` reports these positions.
- R2: While `rst` is high at a clock edge, the controller enters WAIT_RELEASE and `press_valid`, `press_error`, `press_mask` and `press_index` are all driven to 0.
- R3: No event is reported unless the mask has been all zero at a clock edge since the previous event or since reset. Buttons held from reset, held after an event, or changed without a full release produce no `press_valid`.
- R4: When WAIT_PRESS sees a non-zero mask, the next state is CAPTURE. The mask sampled in CAPTURE is the value later shown on `press_mask`.
- R5: On a successful event, `press_index` equals the number of single-place right shifts needed for the captured value to equal 1. This is the position of the highest set bit.
- R6: For a captured mask with highest set bit k, `press_valid` is high in the clock cycle after edge k+3, counted from the first edge at which WAIT_PRESS sees the non-zero mask as edge 1.
- R7: `press_valid` is high for exactly one cycle, after which the block is back in WAIT_RELEASE. `press_mask`, `press_index` and `press_error` then hold their values until the next capture.
- R8: The shift engine evaluates at most `SHIFT_LIMIT` counts (0 to `SHIFT_LIMIT-1`). If the value never equals 1 in that budget, the event reports `press_index` = 0 with `press_error` = 1. This covers a captured zero mask and a highest bit at or above `SHIFT_LIMIT`.
- R9: `press_error` is 0 on every event whose index was found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_lo | input | LO_W (8) | Lower button group |
| btn_hi | input | HI_W (7) | Upper button group |
| press_mask | output | LO_W+HI_W (15) | Captured button mask of the last event |
| press_index | output | clog2(LO_W+HI_W) (4) | Shift count (highest set bit) of the last event |
| press_valid | output | 1 | One-cycle event strobe |
| press_error | output | 1 | Event ended without the value reaching 1 |

## Verification
The bench builds two copies of the block from the same button inputs:
- **Default parameters** (8 + 7 buttons, a budget of 15 shifts). Every one of the fifteen single-button positions, including bit 14 at the very end of the budget, can be pressed and timed. A one-cycle press makes the capture see a zero mask and so exercises the exhausted-budget error.
- **`SHIFT_LIMIT` of 4**. Here a press of bit 4 overruns the budget, which brings the error caused by a bit beyond reach into a short run. Bit 3 stays the last index that can still be found.

// File: rtl/btn_cap_pkg.sv
package btn_cap_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_RELEASE = 3'd0,
        ST_WAIT_PRESS   = 3'd1,
        ST_CAPTURE      = 3'd2,
        ST_SHIFT        = 3'd3,
        ST_DONE         = 3'd4
    } cap_state_t;

endpackage

// File: rtl/btn_mask_merge.sv
module btn_mask_merge #(
    parameter int LO_W   = 8,
    parameter int HI_W   = 7,
    localparam int MASK_W = LO_W + HI_W
) (
    input  logic [LO_W-1:0]   grp_lo,
    input  logic [HI_W-1:0]   grp_hi,
    output logic [MASK_W-1:0] mask,
    output logic              any_down
);

    // lower group keeps its positions, upper group lands above it
    for (genvar i = 0; i < MASK_W; i++) begin : g_bit
        if (i < LO_W) begin : g_lo
            assign mask[i] = grp_lo[i];
        end else begin : g_hi
            assign mask[i] = grp_hi[i-LO_W];
        end
    end

    assign any_down = |mask;

endmodule

// File: rtl/btn_shift_encoder.sv
module btn_shift_encoder #(
    parameter int MASK_W      = 15,
    parameter int SHIFT_LIMIT = 15,
    parameter int IDX_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [MASK_W-1:0] load_value,
    output logic              hit_one,
    output logic              exhausted,
    output logic [IDX_W-1:0]  count
);

    localparam logic [IDX_W-1:0]  LAST = IDX_W'(SHIFT_LIMIT - 1);
    localparam logic [MASK_W-1:0] ONE  = MASK_W'(1);

    logic [MASK_W-1:0] work;

    always_ff @(posedge clk) begin
        if (rst) begin
            work  <= '0;
            count <= '0;
        end else if (load) begin
            work  <= load_value;
            count <= '0;
        end else if (step) begin
            work  <= work >> 1;
            count <= count + 1'b1;
        end
    end

    assign hit_one   = (work == ONE);
    assign exhausted = (count == LAST);

    // the iteration counter never runs past the budget
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
        step |=> count <= LAST);

    // the controller never shifts once the value has reached one
    assert_no_shift_past_one_R5: assert property (@(posedge clk) disable iff (rst)
        hit_one |-> !step);

endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
    import btn_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_down,
    input  logic       hit_one,
    input  logic       exhausted,
    output cap_state_t state,
    output logic       load,
    output logic       step,
    output logic       finish_ok,
    output logic       finish_err
);

    cap_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT_RELEASE;
        else     state <= state_nx;
    end

    // next state and control strobes
    always_comb begin
        state_nx   = state;
        load       = 1'b0;
        step       = 1'b0;
        finish_ok  = 1'b0;
        finish_err = 1'b0;
        unique case (state)
            ST_WAIT_RELEASE: if (!any_down) state_nx = ST_WAIT_PRESS;
            ST_WAIT_PRESS:   if (any_down)  state_nx = ST_CAPTURE;
            ST_CAPTURE: begin
                load     = 1'b1;
                state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (hit_one) begin
                    finish_ok = 1'b1;
                    state_nx  = ST_DONE;
                end else if (exhausted) begin
                    finish_err = 1'b1;
                    state_nx   = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_DONE:  state_nx = ST_WAIT_RELEASE;
            default:  state_nx = ST_WAIT_RELEASE;
        endcase
    end

    assert_release_first_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_RELEASE && any_down) |=> state == ST_WAIT_RELEASE);

    assert_press_to_capture_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_PRESS && any_down) |=> state == ST_CAPTURE);

    assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> $past(state) == ST_SHIFT);

endmodule

// File: rtl/btn_press_capture.sv
module btn_press_capture
    import btn_cap_pkg::*;
#(
    parameter int LO_W        = 8,
    parameter int HI_W        = 7,
    parameter int SHIFT_LIMIT = 15,
    localparam int MASK_W     = LO_W + HI_W,
    localparam int IDX_W      = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LO_W-1:0]   btn_lo,
    input  logic [HI_W-1:0]   btn_hi,
    output logic [MASK_W-1:0] press_mask,
    output logic [IDX_W-1:0]  press_index,
    output logic              press_valid,
    output logic              press_error
);

    logic [MASK_W-1:0] merged;
    logic              any_down;
    logic              hit_one, exhausted;
    logic              load, step, finish_ok, finish_err;
    logic [IDX_W-1:0]  count;
    cap_state_t        state;

    btn_mask_merge #(.LO_W(LO_W), .HI_W(HI_W)) u_merge (
        .grp_lo   (btn_lo),
        .grp_hi   (btn_hi),
        .mask     (merged),
        .any_down (any_down)
    );

    btn_press_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .any_down   (any_down),
        .hit_one    (hit_one),
        .exhausted  (exhausted),
        .state      (state),
        .load       (load),
        .step       (step),
        .finish_ok  (finish_ok),
        .finish_err (finish_err)
    );

    btn_shift_encoder #(
        .MASK_W      (MASK_W),
        .SHIFT_LIMIT (SHIFT_LIMIT),
        .IDX_W       (IDX_W)
    ) u_enc (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (step),
        .load_value (merged),
        .hit_one    (hit_one),
        .exhausted  (exhausted),
        .count      (count)
    );

    // result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            press_mask  <= '0;
            press_index <= '0;
            press_error <= 1'b0;
        end else begin
            if (load) press_mask <= merged;
            if (finish_ok) begin
                press_index <= count;
                press_error <= 1'b0;
            end else if (finish_err) begin
                press_index <= '0;
                press_error <= 1'b1;
            end
        end
    end

    assign press_valid = (state == ST_DONE);

    assert_index_highest_R5: assert property (@(posedge clk) disable iff (rst)
        (press_valid && !press_error) |-> (press_mask >> press_index) == MASK_W'(1));

    assert_error_index_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (press_valid && press_error) |-> press_index == '0);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        press_valid |=> !press_valid);

endmodule

// File: tb/btn_press_capture_test.sv
`timescale 1ns/1ps
module btn_press_capture_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  lo  = '0;
    logic [6:0]  hi  = '0;

    logic [14:0] m0, m1;
    logic [3:0]  i0, i1;
    logic        v0, v1, e0, e1;

    int n_checks = 0;
    int n_bad    = 0;

    always #2.5 clk = ~clk;

    btn_press_capture uut (
        .clk(clk), .rst(rst), .btn_lo(lo), .btn_hi(hi),
        .press_mask(m0), .press_index(i0), .press_valid(v0), .press_error(e0)
    );

    btn_press_capture #(.SHIFT_LIMIT(4)) uut_lim (
        .clk(clk), .rst(rst), .btn_lo(lo), .btn_hi(hi),
        .press_mask(m1), .press_index(i1), .press_valid(v1), .press_error(e1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_mask(input logic [14:0] v);
        lo = v[7:0];
        hi = v[14:8];
    endtask

    task automatic release_all();
        @(negedge clk);
        set_mask('0);
        repeat (22) @(negedge clk);
    endtask

    task automatic wait_report(input int sel, input int maxc,
                               output bit seen, output int n);
        seen = 0;
        n    = 0;
        while (!seen && n < maxc) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if ((sel == 0) ? v0 : v1) seen = 1;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(v0 == 0, "R2", "valid after reset", v0, 0);
        check(m0 == 0, "R2", "mask after reset", m0, 0);
        check(i0 == 0, "R2", "index after reset", i0, 0);
        check(e0 == 0, "R2", "error after reset", e0, 0);
    endtask

    task automatic t_single_bits();
        for (int k = 0; k < 15; k++) begin
            bit seen;
            int n;
            release_all();
            set_mask(15'(1) << k);
            wait_report(0, 40, seen, n);
            check(seen, "R4", "single bit report seen", seen, 1);
            check(n == k + 3, "R6", "latency", n, k + 3);
            check(i0 == 4'(k), "R5", "single bit index", i0, k);
            check(m0 == (15'(1) << k), "R1", "single bit mask", m0, 1 << k);
            check(e0 == 0, "R9", "single bit error", e0, 0);
            @(negedge clk);
            check(v0 == 0, "R7", "valid one cycle", v0, 0);
        end
    endtask

    task automatic t_multi();
        logic [14:0] pats [4];
        int          exp_i [4];
        pats[0] = 15'h4001; exp_i[0] = 14;
        pats[1] = 15'h00FF; exp_i[1] = 7;
        pats[2] = 15'h0300; exp_i[2] = 9;
        pats[3] = 15'h0180; exp_i[3] = 8;
        for (int p = 0; p < 4; p++) begin
            bit seen;
            int n;
            release_all();
            set_mask(pats[p]);
            wait_report(0, 40, seen, n);
            check(seen, "R4", "multi report seen", seen, 1);
            check(i0 == 4'(exp_i[p]), "R5", "highest bit index", i0, exp_i[p]);
            check(m0 == pats[p], "R1", "multi mask", m0, pats[p]);
            check(e0 == 0, "R9", "multi error", e0, 0);
        end
    endtask

    task automatic t_hold();
        bit seen;
        int n;
        release_all();
        set_mask(15'h0020);
        wait_report(0, 40, seen, n);
        check(seen && i0 == 4'd5, "R5", "hold first index", i0, 5);
        wait_report(0, 30, seen, n);
        check(!seen, "R3", "no report while held", seen, 0);
        check(m0 == 15'h0020, "R7", "mask held", m0, 15'h0020);
        check(i0 == 4'd5, "R7", "index held", i0, 5);
        set_mask(15'h7F00);
        wait_report(0, 30, seen, n);
        check(!seen, "R3", "no report on change without release", seen, 0);
        release_all();
        set_mask(15'h0002);
        wait_report(0, 40, seen, n);
        check(seen && i0 == 4'd1, "R3", "report after release", i0, 1);
    endtask

    task automatic t_glitch();
        bit seen;
        int n;
        release_all();
        set_mask(15'h0004);
        @(negedge clk);
        set_mask('0);
        wait_report(0, 40, seen, n);
        check(seen, "R8", "glitch report seen", seen, 1);
        check(e0 == 1, "R8", "glitch error flag", e0, 1);
        check(i0 == 0, "R8", "glitch index", i0, 0);
        check(m0 == 0, "R4", "glitch captured mask", m0, 0);
    endtask

    task automatic t_limit();
        bit seen;
        int n;
        release_all();
        set_mask(15'h0008);
        wait_report(1, 40, seen, n);
        check(seen && i1 == 4'd3, "R8", "limit last reachable index", i1, 3);
        check(e1 == 0, "R9", "limit reachable error", e1, 0);
        release_all();
        set_mask(15'h0010);
        wait_report(1, 40, seen, n);
        check(seen, "R8", "overrun report seen", seen, 1);
        check(n == 6, "R8", "overrun latency", n, 6);
        check(e1 == 1, "R8", "overrun error", e1, 1);
        check(i1 == 0, "R8", "overrun index", i1, 0);
        check(m1 == 15'h0010, "R8", "overrun mask", m1, 15'h0010);
    endtask

    task automatic t_reset_held();
        bit seen;
        int n;
        @(negedge clk);
        set_mask(15'h0001);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(v0 == 0 && e0 == 0, "R2", "reset mid-run flags", {v0, e0}, 0);
        check(m0 == 0 && i0 == 0, "R2", "reset mid-run data", m0, 0);
        rst = 1'b0;
        wait_report(0, 25, seen, n);
        check(!seen, "R3", "held through reset", seen, 0);
        release_all();
        set_mask(15'h0040);
        wait_report(0, 40, seen, n);
        check(seen && i0 == 4'd6, "R3", "report after reset release", i0, 6);
    endtask

    initial begin
        t_reset();
        t_single_bits();
        t_multi();
        t_hold();
        t_glitch();
        t_limit();
        t_reset_held();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule